// File: doc/BRIEF.md
# Assignable-Priority Interrupt Controller

This block arbitrates seventeen interrupt vectors for a processor core. Five vectors come from fixed system sources: hard reset request, emulator, emulator kernel, power-down and stack. The other twelve are ordered user slots. Peripheral request lines do not have a fixed place in the priority order. Each one carries a programmable field that ties it to one of the twelve slots. A peripheral therefore takes the priority of the slot it is tied to, and several peripherals may share a slot.

A rising edge on any source latches a pending bit for its vector. Pending bits are filtered by per-vector enable bits and a global enable. The two topmost vectors bypass both filters. The highest-priority eligible vector is offered to the core as a registered request plus a vector number. The core answers with a one-cycle acknowledge, which retires that vector. Software programs the global enable, the enable bits and the slot fields through a single-cycle write port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_req and irq_vec are 0, the global enable and all enable bits are 0, and every peripheral field is 15 (disconnected).
- R2: Vector numbers fix the priority, and a lower number wins. Vector 0 is reset, 1 is emulator, 2 is emulator kernel, 3 is power-down and 4 is stack. Vectors 5 to 16 are user slots 0 to 11. sys_irq bit i drives vector i.
- R3: Writing address 2+k sets the 4-bit field of peripheral k from wr_data[3:0]. A value v below 12 routes that peripheral to vector 5+v. Values 12 to 15 make the peripheral's requests ignored.
- R4: A pending bit is set only by a rising edge of its source. A level that stays high does not set it again after it has been acknowledged.
- R5: Vectors 0 and 1 are presented whatever the enable bits say. Any other vector i is presented only when enable bit i (address 1, wr_data[i]) and the global enable (address 0, wr_data[0]) are both 1.
- R6: A pending bit that is blocked by the enables is kept. It is presented once the enables allow it.
- R7: An acknowledge while irq_req is 1 clears the pending bit of the presented vector. irq_req is 0 after that edge, and irq_vec is unchanged across the acknowledge cycle.
- R8: A rising edge sampled at clock edge N makes irq_req 1 after edge N+1 when that vector is eligible, no acknowledge is given and no higher vector is eligible.
- R9: An acknowledge while irq_req is 0 has no effect.
- R10: Peripherals routed to the same slot all feed that slot's vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_irq | input | NUM_FIXED (5) | Fixed system source lines, bit i is vector i |
| periph_irq | input | NUM_PERIPH (8) | Peripheral request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | 0 global enable, 1 enable bits, 2+k field of peripheral k |
| wr_data | input | NUM_VEC (17) | Write data |
| irq_ack | input | 1 | Core acknowledge of the presented vector |
| irq_req | output | 1 | An eligible vector is presented |
| irq_vec | output | VEC_W (5) | Presented vector number |

## Verification
The hardest situation to reach is a pending bit that stays hidden behind the enables and is later uncovered. It can also be uncovered while an acknowledge retires a different vector. The bench builds this directly: it latches edges with enables cleared or global enable off, then writes the enables and waits. It also runs random traffic in which enable writes, field changes, shared slots and acknowledges land on the same cycles as new edges. A cycle-accurate bench model predicts every output.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   // fixed vectors, in priority order
   localparam int unsigned VEC_RESET   = 0;
   localparam int unsigned VEC_EMU     = 1;
   localparam int unsigned VEC_KERNEL  = 2;
   localparam int unsigned VEC_PWRDN   = 3;
   localparam int unsigned VEC_STACK   = 4;
   localparam int unsigned FIXED_COUNT = 5;
   // vectors below this index ignore every enable bit
   localparam int unsigned UNMASKED    = 2;
   // register address map
   localparam int unsigned ADR_GEN     = 0;
   localparam int unsigned ADR_MASK    = 1;
   localparam int unsigned ADR_FIELD0  = 2;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
   parameter int unsigned W       = 8,
   parameter int unsigned SYNC_FF = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   logic [W-1:0] lvl_s;
   logic [W-1:0] prev_q;

   generate
      if (SYNC_FF == 0) begin : g_direct
         assign lvl_s = lvl;
      end else begin : g_sync
         logic [W-1:0] sync_q [SYNC_FF];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(SYNC_FF); i++) sync_q[i] <= '0;
            end else begin
               sync_q[0] <= lvl;
               for (int i = 1; i < int'(SYNC_FF); i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign lvl_s = sync_q[SYNC_FF-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_s;
   end

   assign rise = lvl_s & ~prev_q;

   // R4: a line held high never reports a second edge
   p_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise != '0 |=> (rise & $past(rise)) == '0);
endmodule

// File: rtl/irq_slot_map.sv
module irq_slot_map #(
   parameter int unsigned NUM_PERIPH = 8,
   parameter int unsigned NUM_SLOTS  = 12,
   parameter int unsigned FIELD_W    = 4,
   parameter int unsigned ADDR_W     = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [FIELD_W-1:0]    wr_field,
   input  logic [NUM_PERIPH-1:0] rise,
   output logic [NUM_SLOTS-1:0]  slot_hit
);
   import irq_prio_pkg::*;

   localparam logic [FIELD_W-1:0] OFF = '1;

   initial begin
      assert (NUM_SLOTS < (1 << FIELD_W))
         else $fatal(1, "slot field too narrow for NUM_SLOTS plus a disconnect code");
   end

   logic [FIELD_W-1:0] field_q [NUM_PERIPH];

   for (genvar k = 0; k < int'(NUM_PERIPH); k++) begin : g_field
      localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(ADR_FIELD0 + k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         field_q[k] <= OFF;
         else if (wr_en && wr_addr == MY_ADR) field_q[k] <= wr_field;
      end
   end

   for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_slot
      logic [NUM_PERIPH-1:0] hits;
      for (genvar k = 0; k < int'(NUM_PERIPH); k++) begin : g_src
         assign hits[k] = rise[k] && (field_q[k] == FIELD_W'(s));
      end
      assign slot_hit[s] = |hits;
   end

   // R3: an edge on a disconnected peripheral reaches no slot
   p_disc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[0] && field_q[0] >= FIELD_W'(NUM_SLOTS) && rise[NUM_PERIPH-1:1] == '0)
      |-> slot_hit == '0);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned N     = 17,
   parameter int unsigned VEC_W = 5
) (
   input  logic [N-1:0]     elig,
   output logic             any,
   output logic [VEC_W-1:0] idx
);
   initial begin
      assert ((1 << VEC_W) >= N) else $fatal(1, "vector width too small");
   end

   always_comb begin
      any = |elig;
      idx = '0;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (elig[i]) idx = VEC_W'(i);
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int unsigned NUM_PERIPH = 8,
   parameter int unsigned NUM_SLOTS  = 12,
   parameter int unsigned FIELD_W    = 4,
   parameter int unsigned SYNC_FF    = 0,
   parameter int unsigned NUM_FIXED  = irq_prio_pkg::FIXED_COUNT,
   // derived, leave at default
   parameter int unsigned NUM_VEC    = NUM_FIXED + NUM_SLOTS,
   parameter int unsigned VEC_W      = $clog2(NUM_VEC),
   parameter int unsigned ADDR_W     = $clog2(irq_prio_pkg::ADR_FIELD0 + NUM_PERIPH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_FIXED-1:0]  sys_irq,
   input  logic [NUM_PERIPH-1:0] periph_irq,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [NUM_VEC-1:0]    wr_data,
   input  logic                  irq_ack,
   output logic                  irq_req,
   output logic [VEC_W-1:0]      irq_vec
);
   import irq_prio_pkg::*;

   localparam int unsigned NUM_SRC = NUM_FIXED + NUM_PERIPH;

   initial begin
      assert (NUM_FIXED == FIXED_COUNT) else $fatal(1, "fixed source count is set by the package");
      assert (NUM_VEC == NUM_FIXED + NUM_SLOTS) else $fatal(1, "NUM_VEC must not be overridden");
   end

   logic [NUM_SRC-1:0]   src_rise;
   logic [NUM_SLOTS-1:0] slot_hit;
   logic [NUM_VEC-1:0]   vec_set, vec_clr, allow, elig, pend_q, mask_q;
   logic                 gen_q, req_q, pick_any, take;
   logic [VEC_W-1:0]     vec_q, pick_idx;

   irq_edge_capture #(.W(NUM_SRC), .SYNC_FF(SYNC_FF)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl({periph_irq, sys_irq}), .rise(src_rise));

   irq_slot_map #(.NUM_PERIPH(NUM_PERIPH), .NUM_SLOTS(NUM_SLOTS),
                  .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_map (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_field(wr_data[FIELD_W-1:0]), .rise(src_rise[NUM_SRC-1:NUM_FIXED]),
      .slot_hit(slot_hit));

   assign vec_set = {slot_hit, src_rise[NUM_FIXED-1:0]};

   // enable registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q  <= 1'b0;
         mask_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADR_GEN))  gen_q  <= wr_data[0];
         if (wr_addr == ADDR_W'(ADR_MASK)) mask_q <= wr_data;
      end
   end

   for (genvar i = 0; i < int'(NUM_VEC); i++) begin : g_allow
      if (i < int'(UNMASKED)) begin : g_fixed
         assign allow[i] = 1'b1;
      end else begin : g_gated
         assign allow[i] = mask_q[i] & gen_q;
      end
   end

   assign elig = pend_q & allow;

   irq_pick #(.N(NUM_VEC), .VEC_W(VEC_W)) u_pick (
      .elig(elig), .any(pick_any), .idx(pick_idx));

   assign take = irq_ack & req_q;

   always_comb begin
      vec_clr = '0;
      if (take) vec_clr[vec_q] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         req_q  <= 1'b0;
         vec_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~vec_clr) | vec_set;
         if (take) begin
            req_q <= 1'b0;
         end else if (!irq_ack) begin
            req_q <= pick_any;
            if (pick_any) vec_q <= pick_idx;
         end
      end
   end

   assign irq_req = req_q;
   assign irq_vec = vec_q;

   // R7: presented vector holds across an acknowledge, request drops
   p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!irq_req && $stable(irq_vec)));
   // R7: acknowledged vector is retired unless it fired again
   p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !vec_set[vec_q]) |=> !pend_q[$past(vec_q)]);
   // R5: top vector is presented regardless of enables
   p_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[VEC_RESET] && !irq_ack) |=> (irq_req && irq_vec == VEC_W'(VEC_RESET)));
   // R9: acknowledge without a request changes nothing presented
   p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !irq_req) |=> (!irq_req && $stable(irq_vec)));
   // R2: presented vector is always a legal number
   p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_vec < VEC_W'(NUM_VEC));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
   localparam int NP = 8;
   localparam int NS = 12;
   localparam int NF = 5;
   localparam int NV = NF + NS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] sys_irq = '0;
   logic [NP-1:0] periph_irq = '0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [NV-1:0] wr_data = '0;
   logic          irq_ack = 1'b0;
   logic          irq_req;
   logic [4:0]    irq_vec;

   irq_prio_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq), .periph_irq(periph_irq),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_ack(irq_ack),
      .irq_req(irq_req), .irq_vec(irq_vec));

   always #2 clk = ~clk;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   string tag = "R1";

   // bench model
   logic [NV-1:0] m_pend, m_mask;
   logic          m_gen, m_req;
   logic [4:0]    m_vec;
   logic [3:0]    m_fld [NP];
   logic [NF-1:0] m_psys;
   logic [NP-1:0] m_pper;

   task automatic model_reset();
      m_pend = '0; m_mask = '0; m_gen = 1'b0; m_req = 1'b0; m_vec = '0;
      m_psys = '0; m_pper = '0;
      for (int k = 0; k < NP; k++) m_fld[k] = 4'hF;
   endtask

   function automatic int first_elig(input logic [NV-1:0] e);
      for (int i = 0; i < NV; i++) if (e[i]) return i;
      return -1;
   endfunction

   task automatic model_edge();
      logic [NV-1:0] setv, clrv, el;
      int f;
      setv = '0; clrv = '0;
      for (int i = 0; i < NF; i++) if (sys_irq[i] && !m_psys[i]) setv[i] = 1'b1;
      for (int k = 0; k < NP; k++)
         if (periph_irq[k] && !m_pper[k] && m_fld[k] < 4'd12) setv[NF + int'(m_fld[k])] = 1'b1;
      for (int i = 0; i < NV; i++) el[i] = m_pend[i] && (i < 2 || (m_mask[i] && m_gen));
      if (irq_ack && m_req) begin
         clrv[m_vec] = 1'b1;
         m_req = 1'b0;
      end else if (!irq_ack) begin
         f = first_elig(el);
         m_req = (f >= 0);
         if (f >= 0) m_vec = 5'(f);
      end
      m_pend = (m_pend & ~clrv) | setv;
      if (wr_en) begin
         if (wr_addr == 4'd0) m_gen = wr_data[0];
         else if (wr_addr == 4'd1) m_mask = wr_data;
         else if (int'(wr_addr) >= 2 && int'(wr_addr) < 2 + NP) m_fld[int'(wr_addr) - 2] = wr_data[3:0];
      end
      m_psys = sys_irq;
      m_pper = periph_irq;
   endtask

   task automatic chk(input logic ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(irq_req === m_req, "irq_req", int'(irq_req), int'(m_req));
      chk(irq_vec === m_vec, "irq_vec", int'(irq_vec), int'(m_vec));
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = NV'(d);
      tick();
      wr_en = 1'b0;
   endtask

   task automatic ack_once();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0; tick();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      chk(irq_req === 1'b0 && irq_vec === 5'd0, "reset outputs", int'(irq_req), 0);
      periph_irq[0] = 1'b1; tick(); tick();      // disabled and disconnected
      chk(irq_req === 1'b0, "no request after reset", int'(irq_req), 0);
      periph_irq[0] = 1'b0; tick();

      tag = "R3";
      wr(0, 1); wr(1, 'h1FFFF);
      periph_irq[0] = 1'b1; tick(); tick();
      chk(irq_req === 1'b0, "field 15 disconnects", int'(irq_req), 0);
      periph_irq[0] = 1'b0; tick();

      tag = "R8";
      wr(2, 3);
      periph_irq[0] = 1'b1; tick();
      chk(irq_req === 1'b0, "one edge after rise", int'(irq_req), 0);
      tick();
      chk(irq_req === 1'b1 && irq_vec === 5'd8, "slot 3 is vector 8", int'(irq_vec), 8);

      tag = "R2";
      sys_irq[4] = 1'b1; tick(); tick();
      chk(irq_vec === 5'd4, "stack over slot", int'(irq_vec), 4);
      sys_irq[0] = 1'b1; tick(); tick();
      chk(irq_vec === 5'd0, "reset source first", int'(irq_vec), 0);

      tag = "R7";
      irq_ack = 1'b1; tick();
      chk(irq_req === 1'b0 && irq_vec === 5'd0, "ack holds vector", int'(irq_vec), 0);
      irq_ack = 1'b0; tick();
      chk(irq_req === 1'b1 && irq_vec === 5'd4, "next vector after ack", int'(irq_vec), 4);
      ack_once(); ack_once();
      chk(irq_req === 1'b0, "all retired", int'(irq_req), 0);

      tag = "R4";
      repeat (3) tick();
      chk(irq_req === 1'b0, "held level no retrigger", int'(irq_req), 0);

      tag = "R9";
      irq_ack = 1'b1; tick(); irq_ack = 1'b0; tick();
      chk(irq_req === 1'b0, "idle ack", int'(irq_req), 0);
      periph_irq[0] = 1'b0; tick(); periph_irq[0] = 1'b1; tick(); tick();
      chk(irq_req === 1'b1 && irq_vec === 5'd8, "fresh edge after idle ack", int'(irq_vec), 8);
      ack_once();

      tag = "R5";
      wr(1, 0);
      sys_irq = '0; tick();
      sys_irq[1] = 1'b1; tick(); tick();
      chk(irq_req === 1'b1 && irq_vec === 5'd1, "emulator unmaskable", int'(irq_vec), 1);
      ack_once();
      sys_irq[2] = 1'b1; tick(); tick();
      chk(irq_req === 1'b0, "kernel masked", int'(irq_req), 0);

      tag = "R6";
      wr(1, 'h4); tick();
      chk(irq_req === 1'b1 && irq_vec === 5'd2, "kept pending shown", int'(irq_vec), 2);
      ack_once();
      wr(0, 0);
      sys_irq[3] = 1'b1; tick();
      wr(1, 'h1FFFF); tick();
      chk(irq_req === 1'b0, "global enable off", int'(irq_req), 0);
      wr(0, 1); tick();
      chk(irq_req === 1'b1 && irq_vec === 5'd3, "global enable on", int'(irq_vec), 3);
      ack_once();

      tag = "R10";
      wr(3, 7); wr(4, 7);
      periph_irq[1] = 1'b1; tick(); tick();
      chk(irq_req === 1'b1 && irq_vec === 5'd12, "first sharer", int'(irq_vec), 12);
      ack_once();
      periph_irq[2] = 1'b1; tick(); tick();
      chk(irq_req === 1'b1 && irq_vec === 5'd12, "second sharer", int'(irq_vec), 12);
      ack_once();

      tag = "R2 R5 R6 R7 random";
      for (int n = 0; n < 3000; n++) begin
         sys_irq    = ($urandom % 8 == 0) ? NF'($urandom) : sys_irq;
         periph_irq = ($urandom % 3 == 0) ? NP'($urandom) : periph_irq;
         irq_ack    = ($urandom % 3 == 0);
         wr_en      = ($urandom % 10 == 0);
         wr_addr    = 4'($urandom % 12);
         wr_data    = NV'($urandom);
         if (wr_addr == 4'd0) wr_data[0] = ($urandom % 4 != 0);
         tick();
      end
      wr_en = 1'b0; irq_ack = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule